// File: doc/BRIEF.md
# NRZI Line Encoder with Run-Length Bit Insertion

This block converts a serial stream of data bits into line states for a differential pair that uses transition-on-zero coding. Each data bit arrives on a valid/ready handshake and is placed on the line in a single bit slot. A bit slot is a clock cycle in which the bit-rate enable input is high. A data 0 flips the line level. A data 1 holds the line level.

Long runs of 1s would leave the line without edges, and the far end would lose its bit clock. To prevent this, the block counts consecutive 1s. Once the count reaches the run limit, the block spends the next bit slot sending an extra 0. It holds its ready output low in that slot, so the source keeps its pending bit until the following slot.

The two outputs are always complements of each other. An output-enable marks the slots that carry a bit. A bit slot that carries neither a data bit nor a pending inserted 0 ends the packet. In that slot the line returns to its idle level (positive leg high), the enable drops, and the run count starts over for the next packet.

Top module: `usb_nrzi_stuffer`

## Requirements
- R1: After reset, dp_o is 1, dm_o is 0, oe_o is 0, and bit_ready_o is 0 whenever bit_en_i is 0.
- R2: In a bit slot that accepts a data bit of value 0, dp_o inverts after that clock edge and oe_o is 1.
- R3: In a bit slot that accepts a data bit of value 1, dp_o keeps its level after that clock edge and oe_o is 1.
- R4: After RUN_LEN (default 6) accepted 1s in a row, the next bit slot inserts a 0. In that slot bit_ready_o is 0, dp_o inverts, and the offered bit is not consumed.
- R5: The inserted 0 clears the run count, so RUN_LEN further 1s are needed before the next insertion.
- R6: An accepted 0 clears the run count, so RUN_LEN-1 ones, then a 0, then RUN_LEN-1 ones produce no insertion.
- R7: dm_o equals the inverse of dp_o in every cycle.
- R8: A bit slot with bit_valid_i low and no insertion pending drives dp_o to 1 and oe_o to 0 after the edge, and clears the run count.
- R9: In a cycle with bit_en_i low, dp_o, dm_o and oe_o keep their values, and no bit is consumed.
- R10: An insertion that is pending is sent in the next bit slot even when bit_valid_i is low. The end of the packet then follows in a later idle slot.
- R11: A run of 1s interrupted by an idle slot does not count across the idle slot. Three 1s, an idle slot, then four 1s produce no insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | Bit-rate enable; one line bit per high cycle |
| bit_valid_i | input | 1 | Source offers a data bit |
| bit_i | input | 1 | Offered data bit |
| bit_ready_o | output | 1 | Offered bit is consumed in this cycle when valid is also high |
| dp_o | output | 1 | Positive line leg |
| dm_o | output | 1 | Negative line leg, complement of dp_o |
| oe_o | output | 1 | Line driver enable |

## Verification
Three events can fall in the same bit slot:
- the insertion of the forced 0;
- a data bit that is offered but must be held back;
- the end of a packet.

The bench sets these up by offering a further 1, or by dropping valid, in exactly the slot after the sixth accepted 1. It then checks three things in that slot:
- ready reads 0 and the offered bit is not consumed;
- the line flips;
- the end-of-packet return to idle is deferred to a later slot.

Every result is compared against an independent model of the line level and the run count.

// File: rtl/usb_nrzi_pkg.sv
package usb_nrzi_pkg;
  localparam logic IDLE_LEVEL = 1'b1;

  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_STUFF = 2'd2,
    SLOT_IDLE  = 2'd3
  } slot_e;
endpackage

// File: rtl/usb_stuff_ctl.sv
module usb_stuff_ctl
  import usb_nrzi_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_en_i,
  input  logic  bit_valid_i,
  input  logic  bit_i,
  output logic  bit_ready_o,
  output slot_e slot_o,
  output logic  tx_bit_o
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0] run_q, run_d;
  logic stuff_due;

  assign stuff_due   = (run_q == RUN_MAX);
  assign bit_ready_o = bit_en_i && !stuff_due;

  always_comb begin
    slot_o   = SLOT_NONE;
    tx_bit_o = 1'b0;
    if (bit_en_i) begin
      if (stuff_due) begin
        slot_o = SLOT_STUFF;
      end else if (bit_valid_i) begin
        slot_o   = SLOT_DATA;
        tx_bit_o = bit_i;
      end else begin
        slot_o = SLOT_IDLE;
      end
    end
  end

  always_comb begin
    run_d = run_q;
    unique case (slot_o)
      SLOT_DATA:  run_d = tx_bit_o ? run_q + RUN_W'(1) : '0;
      SLOT_STUFF: run_d = '0;
      SLOT_IDLE:  run_d = '0;
      default:    run_d = run_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end
endmodule

// File: rtl/usb_nrzi_line.sv
module usb_nrzi_line
  import usb_nrzi_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  slot_e slot_i,
  input  logic  tx_bit_i,
  output logic  line_o,
  output logic  oe_o
);
  logic line_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= IDLE_LEVEL;
      oe_q   <= 1'b0;
    end else begin
      unique case (slot_i)
        SLOT_DATA, SLOT_STUFF: begin
          line_q <= line_q ^ ~tx_bit_i;  // zero flips the line
          oe_q   <= 1'b1;
        end
        SLOT_IDLE: begin
          line_q <= IDLE_LEVEL;
          oe_q   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign line_o = line_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/usb_nrzi_stuffer.sv
module usb_nrzi_stuffer
  import usb_nrzi_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic bit_ready_o,
  output logic dp_o,
  output logic dm_o,
  output logic oe_o
);
  slot_e slot;
  logic  tx_bit;
  logic  line;

  usb_stuff_ctl #(.RUN_LEN(RUN_LEN)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .bit_ready_o (bit_ready_o),
    .slot_o      (slot),
    .tx_bit_o    (tx_bit)
  );

  usb_nrzi_line u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slot_i   (slot),
    .tx_bit_i (tx_bit),
    .line_o   (line),
    .oe_o     (oe_o)
  );

  assign dp_o = line;
  assign dm_o = ~line;
endmodule

// File: rtl/usb_nrzi_stuffer_chk.sv
module usb_nrzi_stuffer_chk #(
  parameter int RUN_LEN = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic bit_valid_i,
  input logic bit_i,
  input logic bit_ready_o,
  input logic dp_o,
  input logic dm_o,
  input logic oe_o
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0] ones_q;
  logic take;
  assign take = bit_valid_i && bit_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ones_q <= '0;
    else if (bit_en_i && take)  ones_q <= bit_i ? ones_q + RUN_W'(1) : '0;
    else if (bit_en_i)          ones_q <= '0;
  end

  assert_take_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !bit_i) |=> (dp_o != $past(dp_o)) && oe_o);

  assert_take_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && bit_i) |=> $stable(dp_o) && oe_o);

  assert_stuff_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && ones_q == RUN_MAX) |-> !bit_ready_o);

  assert_stuff_flip_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && ones_q == RUN_MAX) |=> (dp_o != $past(dp_o)) && oe_o);

  assert_diff_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_o == ~dp_o);

  assert_idle_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !bit_valid_i && ones_q != RUN_MAX) |=> dp_o && !oe_o);

  assert_no_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(dp_o) && $stable(oe_o));

  assert_ready_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |-> !bit_ready_o);
endmodule

bind usb_nrzi_stuffer usb_nrzi_stuffer_chk #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_en_i    (bit_en_i),
  .bit_valid_i (bit_valid_i),
  .bit_i       (bit_i),
  .bit_ready_o (bit_ready_o),
  .dp_o        (dp_o),
  .dm_o        (dm_o),
  .oe_o        (oe_o)
);

// File: tb/sim_usb_nrzi_stuffer.sv
module sim_usb_nrzi_stuffer;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LEN    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, bit_valid = 1'b0, bit_d = 1'b0;
  logic bit_ready, dp, dm, oe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  dp;
    logic  oe;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  logic m_line = 1'b1;
  logic m_oe = 1'b0;
  int   m_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_nrzi_stuffer #(.RUN_LEN(RUN_LEN)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bit_en_i    (bit_en),
    .bit_valid_i (bit_valid),
    .bit_i       (bit_d),
    .bit_ready_o (bit_ready),
    .dp_o        (dp),
    .dm_o        (dm),
    .oe_o        (oe)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock cycle of stimulus; updates the model and queues the expected line
  task automatic slot(input logic en, input logic v, input logic b,
                      input string tag, output bit took);
    logic exp_ready;
    exp_t e;
    @(negedge clk);
    bit_en = en; bit_valid = v; bit_d = b;
    #1;
    exp_ready = en && (m_run != RUN_LEN);
    check(bit_ready === exp_ready, tag, "ready", int'(bit_ready), int'(exp_ready));
    took = en && v && exp_ready;
    if (en) begin
      if (m_run == RUN_LEN) begin
        m_line = ~m_line; m_oe = 1'b1; m_run = 0;
      end else if (v) begin
        m_oe = 1'b1;
        if (!b) begin m_line = ~m_line; m_run = 0; end
        else m_run++;
      end else begin
        m_line = 1'b1; m_oe = 1'b0; m_run = 0;
      end
    end
    e.dp = m_line; e.oe = m_oe; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send_bit(input logic b, input string tag);
    bit took;
    took = 1'b0;
    while (!took) slot(1'b1, 1'b1, b, tag, took);
  endtask

  task automatic send_ones(input int n, input string tag);
    for (int i = 0; i < n; i++) send_bit(1'b1, tag);
  endtask

  task automatic idle_slot(input string tag);
    bit took;
    slot(1'b1, 1'b0, 1'b0, tag, took);
  endtask

  task automatic gap(input string tag);
    bit took;
    slot(1'b0, 1'b1, 1'b0, tag, took);
  endtask

  // monitor: pops one expected item per cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(dp === e.dp, e.tag, "dp", int'(dp), int'(e.dp));
        check(oe === e.oe, e.tag, "oe", int'(oe), int'(e.oe));
        check(dm === ~e.dp, "R7", "dm", int'(dm), int'(~e.dp));
      end
    end
  end

  initial begin
    int stuffed_cnt;
    bit took;
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dp === 1'b1, "R1", "reset dp", int'(dp), 1);
    check(dm === 1'b0, "R1", "reset dm", int'(dm), 0);
    check(oe === 1'b0, "R1", "reset oe", int'(oe), 0);
    check(bit_ready === 1'b0, "R1", "reset ready", int'(bit_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dp === 1'b1 && oe === 1'b0, "R1", "after release", int'({dp, oe}), 2);

    // plain data, zeros flip, ones hold
    send_bit(1'b0, "R2");
    send_bit(1'b1, "R3");
    send_bit(1'b0, "R2");
    gap("R9");
    send_bit(1'b0, "R2");
    send_bit(1'b1, "R3");
    gap("R9");
    idle_slot("R8");

    // six ones, then the offered seventh is held during insertion
    send_ones(RUN_LEN, "R4");
    send_bit(1'b1, "R4");
    // after insertion the count restarts: five more ones, then the sixth
    send_ones(RUN_LEN - 1, "R5");
    send_bit(1'b1, "R5");
    send_bit(1'b1, "R5");
    idle_slot("R8");

    // a zero breaks the run
    send_ones(RUN_LEN - 1, "R6");
    send_bit(1'b0, "R6");
    send_ones(RUN_LEN - 1, "R6");
    send_bit(1'b0, "R6");
    idle_slot("R8");

    // insertion pending while source goes quiet
    send_ones(RUN_LEN, "R10");
    gap("R9");
    idle_slot("R10");
    idle_slot("R10");

    // idle slot splits a run
    send_ones(3, "R11");
    idle_slot("R11");
    send_ones(4, "R11");
    send_bit(1'b0, "R11");
    idle_slot("R8");

    @(negedge clk);
    bit_en = 1'b0; bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule